// File: doc/BRIEF.md
# Serial Configuration Register Bank with LO Routing

This block is a three-wire serial slave that receives 24-bit configuration words and stores each one in one of eight 24-bit registers. It runs entirely on a fast system clock. The serial clock, data and load strobe pass through two-flop synchronizers, and their edges are detected in the system clock domain. For this reason the system clock must run at least four times faster than the serial clock, and each serial clock phase must last at least two system clock cycles.

Data enters most significant bit first, one bit on every rising serial clock edge. On a rising edge of the load strobe, the last 24 bits shifted in are copied into the register chosen by the word's three lowest bits. Any write to register 0, 1 or 2 also produces a one-cycle calibration-start pulse that carries the register index.

The block also decides how the LO is routed. It combines two external pins (PLL enable and LO driver enable) with two bits of register 5, and from them drives an internal/external LO select and an LO output buffer enable. All other register fields leave the block as raw bits.

Top module: `cfg_serial_bank`

## Requirements
- R1: After reset all eight registers read zero, cal_start_o is low, and both LO outputs are low. Reset produces no calibration pulse.
- R2: One bit of ser_data_i is captured on each rising edge of ser_clk_i, and the first bit sent becomes bit 23 of the word.
- R3: A rising edge of ser_load_i writes the shifted word into the register whose index equals word bits [2:0]. All other registers keep their contents.
- R4: The stored value is the complete 24-bit word, including bits [2:0]. Register k is visible at regs_o[24*k+23 : 24*k].
- R5: A write to register 0, 1 or 2 raises cal_start_o for exactly one system clock, in the same cycle the new value appears on regs_o, with cal_idx_o equal to the index. A write to registers 3 to 7 raises no pulse.
- R6: If pll_en_pin_i is 0, or register 5 bit 6 is 0, then lo_internal_o is 0 (external LO) and lo_buf_en_o is 0.
- R7: If pll_en_pin_i is 1 and register 5 bit 6 is 1, then lo_internal_o is 1, and lo_buf_en_o is the OR of lo_drv_pin_i and register 5 bit 3.
- R8: If more or fewer than 24 bits arrive before the load strobe, the last 24 bits shifted in are the ones stored.
- R9: Serial clock and data activity without a load strobe changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_load_i | input | 1 | Load strobe; a rising edge commits the word |
| pll_en_pin_i | input | 1 | External PLL enable pin |
| lo_drv_pin_i | input | 1 | External LO driver enable pin |
| regs_o | output | 192 | All eight registers; register k in bits [24k+23:24k] |
| cal_start_o | output | 1 | One-cycle calibration-start pulse |
| cal_idx_o | output | 3 | Index of the register that triggered calibration |
| lo_internal_o | output | 1 | 1 = internal LO, 0 = external LO |
| lo_buf_en_o | output | 1 | LO output buffer enable |

## Verification
The assertions check on every cycle that:
- the calibration pulse lasts one cycle and carries an index below three;
- the register named by that index holds a word whose address field matches it;
- the LO buffer is never enabled while the LO is external;
- a low PLL enable pin forces external routing.

Only the bench scenarios can show the rest:
- MSB-first bit ordering;
- correct address decode with all other registers left intact;
- the last-24-bits rule for words of the wrong length;
- the absence of any pulse for writes to registers 3 to 7;
- the full truth table of LO routing against the register bits.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int unsigned WORD_W   = 24;
  localparam int unsigned N_REGS   = 8;
  localparam int unsigned CAL_REGS = 3;
  localparam int unsigned LO_REG   = 5;
  localparam int unsigned PLLEN_B  = 6;
  localparam int unsigned LDRV_B   = 3;
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sload_i,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o
);
  logic              sclk_q, sload_q;
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      sload_q <= 1'b0;
      sh_q    <= '0;
    end else begin
      sclk_q  <= sclk_i;
      sload_q <= sload_i;
      if (sclk_i && !sclk_q) sh_q <= {sh_q[WORD_W-2:0], sdata_i};
    end
  end

  assign word_o = sh_q;
  assign load_o = sload_i && !sload_q;
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int unsigned WORD_W   = 24,
  parameter int unsigned N_REGS   = 8,
  parameter int unsigned CAL_REGS = 3,
  localparam int unsigned ADDR_W  = $clog2(N_REGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [WORD_W-1:0]        word_i,
  output logic [N_REGS*WORD_W-1:0] regs_o,
  output logic                     cal_start_o,
  output logic [ADDR_W-1:0]        cal_idx_o
);
  logic [ADDR_W-1:0] addr;
  assign addr = word_i[ADDR_W-1:0];

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    logic [WORD_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r_q <= '0;
      else if (load_i && addr == ADDR_W'(k)) r_q <= word_i;
    end
    assign regs_o[k*WORD_W +: WORD_W] = r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_start_o <= 1'b0;
      cal_idx_o   <= '0;
    end else begin
      cal_start_o <= load_i && (int'(addr) < CAL_REGS);
      if (load_i) cal_idx_o <= addr;
    end
  end
endmodule

// File: rtl/lo_route.sv
module lo_route (
  input  logic pll_pin_i,
  input  logic drv_pin_i,
  input  logic pll_bit_i,
  input  logic drv_bit_i,
  output logic internal_o,
  output logic buf_en_o
);
  always_comb begin
    internal_o = pll_pin_i && pll_bit_i;
    buf_en_o   = internal_o && (drv_pin_i || drv_bit_i);
  end
endmodule

// File: rtl/cfg_serial_bank.sv
module cfg_serial_bank
  import cfg_serial_pkg::*;
#(
  parameter int unsigned WORD_W   = cfg_serial_pkg::WORD_W,
  parameter int unsigned N_REGS   = cfg_serial_pkg::N_REGS,
  parameter int unsigned CAL_REGS = cfg_serial_pkg::CAL_REGS,
  parameter int unsigned LO_REG   = cfg_serial_pkg::LO_REG,
  parameter int unsigned PLLEN_B  = cfg_serial_pkg::PLLEN_B,
  parameter int unsigned LDRV_B   = cfg_serial_pkg::LDRV_B,
  localparam int unsigned ADDR_W  = $clog2(N_REGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ser_clk_i,
  input  logic                     ser_data_i,
  input  logic                     ser_load_i,
  input  logic                     pll_en_pin_i,
  input  logic                     lo_drv_pin_i,
  output logic [N_REGS*WORD_W-1:0] regs_o,
  output logic                     cal_start_o,
  output logic [ADDR_W-1:0]        cal_idx_o,
  output logic                     lo_internal_o,
  output logic                     lo_buf_en_o
);
  logic [2:0]        ser_s;
  logic [WORD_W-1:0] word;
  logic              load;

  sync_bits #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_load_i, ser_data_i, ser_clk_i}),
    .q_o   (ser_s)
  );

  ser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (ser_s[0]),
    .sdata_i(ser_s[1]),
    .sload_i(ser_s[2]),
    .word_o (word),
    .load_o (load)
  );

  reg_bank #(.WORD_W(WORD_W), .N_REGS(N_REGS), .CAL_REGS(CAL_REGS)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .word_i     (word),
    .regs_o     (regs_o),
    .cal_start_o(cal_start_o),
    .cal_idx_o  (cal_idx_o)
  );

  lo_route u_lo (
    .pll_pin_i (pll_en_pin_i),
    .drv_pin_i (lo_drv_pin_i),
    .pll_bit_i (regs_o[LO_REG*WORD_W + PLLEN_B]),
    .drv_bit_i (regs_o[LO_REG*WORD_W + LDRV_B]),
    .internal_o(lo_internal_o),
    .buf_en_o  (lo_buf_en_o)
  );
endmodule

// File: rtl/cfg_serial_bank_chk.sv
module cfg_serial_bank_chk #(
  parameter int unsigned WORD_W   = 24,
  parameter int unsigned N_REGS   = 8,
  parameter int unsigned CAL_REGS = 3,
  localparam int unsigned ADDR_W  = $clog2(N_REGS)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     pll_en_pin_i,
  input logic [N_REGS*WORD_W-1:0] regs_o,
  input logic                     cal_start_o,
  input logic [ADDR_W-1:0]        cal_idx_o,
  input logic                     lo_internal_o,
  input logic                     lo_buf_en_o
);
  p_cal_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |=> !cal_start_o);
  p_cal_idx_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |-> (int'(cal_idx_o) < CAL_REGS));
  p_cal_word_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |-> (regs_o[cal_idx_o*WORD_W +: ADDR_W] == cal_idx_o));
  p_buf_needs_int_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_buf_en_o |-> lo_internal_o);
  p_pin_low_ext_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_en_pin_i |-> (!lo_internal_o && !lo_buf_en_o));
endmodule

bind cfg_serial_bank cfg_serial_bank_chk #(
  .WORD_W(WORD_W), .N_REGS(N_REGS), .CAL_REGS(CAL_REGS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pll_en_pin_i (pll_en_pin_i),
  .regs_o       (regs_o),
  .cal_start_o  (cal_start_o),
  .cal_idx_o    (cal_idx_o),
  .lo_internal_o(lo_internal_o),
  .lo_buf_en_o  (lo_buf_en_o)
);

// File: tb/sim_cfg_serial_bank.sv
`timescale 1ns/1ps
module sim_cfg_serial_bank;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic pll_pin = 1'b0, drv_pin = 1'b0;
  logic [191:0] regs;
  logic cal_start, lo_int, lo_buf;
  logic [2:0] cal_idx;

  always #5 clk = ~clk;

  cfg_serial_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .ser_load_i(ser_load), .pll_en_pin_i(pll_pin), .lo_drv_pin_i(drv_pin),
    .regs_o(regs), .cal_start_o(cal_start), .cal_idx_o(cal_idx),
    .lo_internal_o(lo_int), .lo_buf_en_o(lo_buf)
  );

  int n_chk = 0, n_bad = 0;
  int cal_cnt = 0, cal_run = 0, cal_max = 0;
  logic [2:0] cal_last = '0;
  logic [23:0] exp_r [8];
  bit done = 1'b0;

  always @(posedge clk) begin
    if (cal_start) begin
      cal_cnt++; cal_last = cal_idx; cal_run++;
      if (cal_run > cal_max) cal_max = cal_run;
    end else cal_run = 0;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); ser_data = v[i];
      repeat (3) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_load();
    repeat (3) @(negedge clk); ser_load = 1'b1;
    repeat (4) @(negedge clk); ser_load = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 8; k++) chk(req, 64'(regs[k*24 +: 24]), 64'(exp_r[k]));
  endtask

  function automatic logic [1:0] lo_model(input logic pp, input logic dp, input logic [23:0] r5);
    logic in_l;
    in_l = pp & r5[6];
    return {in_l, in_l & (dp | r5[3])};
  endfunction

  task automatic write_word(input logic [23:0] w, input string req);
    int c0;
    logic exp_cal;
    c0 = cal_cnt;
    send_bits(64'(w), 24);
    pulse_load();
    exp_r[w[2:0]] = w;
    check_all(req);
    exp_cal = (w[2:0] < 3);
    chk("R5 pulse count", 64'(cal_cnt - c0), exp_cal ? 64'd1 : 64'd0);
    if (exp_cal) chk("R5 index", 64'(cal_last), 64'(w[2:0]));
  endtask

  initial begin
    void'($urandom(32'h5eed_0c1b));
    for (int k = 0; k < 8; k++) exp_r[k] = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check_all("R1 reset regs");
    chk("R1 cal count", 64'(cal_cnt), 64'd0);
    chk("R1 lo outputs", {62'd0, lo_int, lo_buf}, 64'd0);

    // R2 / R4: MSB-first word, control bits kept
    write_word(24'hA5C3_F4, "R2 msb-first reg4");
    write_word(24'h12_3456, "R4 reg6 whole word");
    write_word(24'h80_0001, "R3 reg1 decode");
    write_word(24'h7F_FFF8, "R5 reg0 write");
    write_word(24'h00_0002, "R5 reg2 write");
    write_word(24'hFF_FFFF, "R3 reg7 others kept");

    // R9: shift without load changes nothing
    send_bits(64'hDEAD_BE, 24);
    repeat (8) @(negedge clk);
    check_all("R9 no load");
    chk("R9 no pulse", 64'(cal_run), 64'd0);

    // R8: 30-bit word keeps last 24; then a short word after priming
    begin
      int c0;
      c0 = cal_cnt;
      send_bits(64'h3F_ABCD_EF05, 30);
      pulse_load();
      exp_r[5] = 24'hCD_EF05;
      check_all("R8 long word");
      send_bits(64'h0000_0C, 8);
      pulse_load();
      exp_r[4] = 24'hEF_050C;
      check_all("R8 short word");
      chk("R5 no pulse reg3-7", 64'(cal_cnt - c0), 64'd0);
    end

    // R6 / R7: full routing table
    for (int r = 0; r < 4; r++) begin
      logic [23:0] w5;
      w5 = {16'h0, 1'b0, r[1], 2'b00, r[0], 3'b101};
      write_word(w5, "R7 reg5 write");
      for (int p = 0; p < 4; p++) begin
        logic [1:0] e;
        @(negedge clk); pll_pin = p[1]; drv_pin = p[0];
        @(negedge clk);
        e = lo_model(p[1], p[0], w5);
        chk((p[1] && r[1]) ? "R7 lo route" : "R6 lo external",
            {62'd0, lo_int, lo_buf}, 64'(e));
      end
    end

    // random writes
    for (int i = 0; i < 40; i++) begin
      logic [23:0] w;
      w = 24'($urandom);
      write_word(w, "R3 random write");
      @(negedge clk); pll_pin = 1'($urandom); drv_pin = 1'($urandom);
      @(negedge clk);
      chk("R7 random lo", {62'd0, lo_int, lo_buf}, 64'(lo_model(pll_pin, drv_pin, exp_r[5])));
    end
    chk("R5 pulse width", 64'(cal_max), 64'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule